// File: doc/BRIEF.md
# Pairwise IQ Downconverter

The block turns a stream of real ADC samples into baseband I and Q words. It does not mix each sample by cosine and sine on its own. Instead it takes two consecutive samples together and combines them through a 2x2 matrix built from the local-oscillator values at both sampling instants. The sampling instants are labelled first (index 0) and second (index 1). The I word is S1·X0 − S0·X1 and the Q word is C0·X1 − C1·X0. Here X is the ADC sample and C and S are the LO cosine and sine words that arrive with that sample.

An external oscillator supplies the LO words, one per sample, next to the data. The block holds the first sample's values so that each product uses the LO word from the correct instant. A select input tells the block which sample of the pair is present. Two signed multipliers are shared between the I and Q terms on successive cycles, so the output is one stream with I and Q alternating. Gate and trigger strobes travel through the same pipeline. A one-cycle error flag reports a pair select that disagrees with the block's own pair tracking.

Top module: `iq_pair_downconv`

## Requirements
- R1: For a completed pair, the first output word is I = sat(floor((S1·X0 − S0·X1) / 2^17)), where index 0 is the gated sample with pair_sel=0 and index 1 is the following gated sample with pair_sel=1.
- R2: The second output word of the pair is Q = sat(floor((C0·X1 − C1·X0) / 2^17)).
- R3: sat() clamps the result to the range −32768 to 32767 of the 16-bit output.
- R4: The I word appears on iq_data with iq_gate high after the second rising edge that follows the edge capturing the pair's second sample. The Q word follows on the next cycle, also with iq_gate high.
- R5: iq_trig is high together with the I word when adc_trig was high on either sample of the pair. It is low on the Q word.
- R6: A cycle with adc_gate low changes no state: its data, LO, pair_sel and adc_trig values produce no output and no phase error.
- R7: The block expects pair_sel=0 after reset. After each gated sample it expects the inverse of that sample's pair_sel. A gated sample whose pair_sel differs from the expected value raises phase_err for exactly the one cycle after the edge that captured it.
- R8: After a mismatch, a pair_sel=0 sample still becomes the new first sample. A mismatched pair_sel=1 sample is discarded and produces no output.
- R9: While rst_n is low, iq_gate, iq_trig and phase_err are cleared at the clock edge, iq_data becomes 0, and the expected pair select returns to 0.
- R10: iq_data keeps its last value on every cycle in which iq_gate is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| pair_sel | input | 1 | 0 marks the first sample of a pair, 1 the second |
| lo_cos | input | 18 | Signed LO cosine word for the current sample; −131072 never occurs |
| lo_sin | input | 18 | Signed LO sine word for the current sample; −131072 never occurs |
| adc_data | input | 16 | Signed ADC sample |
| adc_gate | input | 1 | Sample valid strobe |
| adc_trig | input | 1 | Trigger marker attached to the sample |
| iq_data | output | 16 | Signed output, I and Q alternating |
| iq_gate | output | 1 | Output word valid |
| iq_trig | output | 1 | Trigger marker on the I word of a pair |
| phase_err | output | 1 | One-cycle pair-select mismatch flag |

## Verification
The bound checker watches the strobe structure on every cycle:
- valid runs come in whole I/Q pairs, each starting three edges after a second sample;
- the trigger sits only on the I word;
- the phase flag follows an independent model of the expected pair select and appears only after gated inputs;
- the data holds while the gate is low.

The values of I and Q can only be shown by the bench scenarios, which compare every output word against reference arithmetic. Those scenarios cover sinusoidal LO and ADC streams with and without idle gaps, saturation at both rails, trigger placement, and both kinds of pair-select mismatch.

// File: rtl/iqdc_pkg.sv
// Shared definitions for the pairwise IQ downconverter.
// Assumes nothing beyond IEEE 1800-2017 packages.
package iqdc_pkg;
    // Which output component the shared multipliers are forming.
    typedef enum logic {
        TERM_I = 1'b0,
        TERM_Q = 1'b1
    } term_e;

    // Number of time-shared multiplier lanes.
    localparam int unsigned NUM_LANES = 2;
endpackage

// File: rtl/iqdc_pair_capture.sv
// Pair capture: tracks the expected pair select, holds the first sample of a
// pair with its LO words, and hands over a complete pair when a matching
// second sample arrives. It raises a one-cycle phase error on mismatch.
// Assumes at most one gated sample per clock.
module iqdc_pair_capture #(
    parameter int unsigned X_W = 16,
    parameter int unsigned L_W = 18
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  smp_gate,
    input  logic                  smp_sel,
    input  logic                  smp_trig,
    input  logic signed [X_W-1:0] smp_x,
    input  logic signed [L_W-1:0] smp_c,
    input  logic signed [L_W-1:0] smp_s,
    output logic signed [X_W-1:0] pr_x0,
    output logic signed [X_W-1:0] pr_x1,
    output logic signed [L_W-1:0] pr_c0,
    output logic signed [L_W-1:0] pr_c1,
    output logic signed [L_W-1:0] pr_s0,
    output logic signed [L_W-1:0] pr_s1,
    output logic                  pr_trig,
    output logic                  pr_go,
    output logic                  ph_err
);
    logic                  exp_sel;
    logic signed [X_W-1:0] h_x;
    logic signed [L_W-1:0] h_c;
    logic signed [L_W-1:0] h_s;
    logic                  h_trig;
    logic                  mism;
    logic                  take_first;
    logic                  take_second;

    // Decode what the current sample does to the pair state.
    always_comb begin
        mism        = smp_gate && (smp_sel != exp_sel);
        take_first  = smp_gate && !smp_sel;
        take_second = smp_gate && smp_sel && !mism;
    end

    // Pair-select tracking and mismatch flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_sel <= 1'b0;
            ph_err  <= 1'b0;
        end else begin
            ph_err <= mism;
            if (smp_gate) begin
                exp_sel <= ~smp_sel;
            end
        end
    end

    // Hold the first sample of a pair together with its LO words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_x    <= '0;
            h_c    <= '0;
            h_s    <= '0;
            h_trig <= 1'b0;
        end else if (take_first) begin
            h_x    <= smp_x;
            h_c    <= smp_c;
            h_s    <= smp_s;
            h_trig <= smp_trig;
        end
    end

    // Present a complete pair to the multiplier stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pr_x0   <= '0;
            pr_x1   <= '0;
            pr_c0   <= '0;
            pr_c1   <= '0;
            pr_s0   <= '0;
            pr_s1   <= '0;
            pr_trig <= 1'b0;
            pr_go   <= 1'b0;
        end else begin
            pr_go <= take_second;
            if (take_second) begin
                pr_x0   <= h_x;
                pr_c0   <= h_c;
                pr_s0   <= h_s;
                pr_x1   <= smp_x;
                pr_c1   <= smp_c;
                pr_s1   <= smp_s;
                pr_trig <= h_trig | smp_trig;
            end
        end
    end
endmodule

// File: rtl/iqdc_mult_stage.sv
// Time-shared multiplier stage: two signed multipliers form the I products
// in the cycle after a pair is presented and the Q products in the cycle
// after that. Lane A carries the term that is added, lane B the one that is
// subtracted. Assumes pairs are presented no more often than every 2 cycles.
module iqdc_mult_stage
    import iqdc_pkg::*;
#(
    parameter int unsigned X_W = 16,
    parameter int unsigned L_W = 18,
    localparam int unsigned P_W = X_W + L_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic signed [X_W-1:0] pr_x0,
    input  logic signed [X_W-1:0] pr_x1,
    input  logic signed [L_W-1:0] pr_c0,
    input  logic signed [L_W-1:0] pr_c1,
    input  logic signed [L_W-1:0] pr_s0,
    input  logic signed [L_W-1:0] pr_s1,
    input  logic                  pr_trig,
    input  logic                  pr_go,
    output logic signed [P_W-1:0] prod_a,
    output logic signed [P_W-1:0] prod_b,
    output logic                  prod_vld,
    output term_e                 prod_term,
    output logic                  prod_trig
);
    logic                  q_next;
    term_e                 term;
    logic signed [L_W-1:0] lo_op [NUM_LANES];
    logic signed [X_W-1:0] x_op  [NUM_LANES];
    logic signed [P_W-1:0] prod  [NUM_LANES];

    // Select the operands for the component being formed this cycle.
    always_comb begin
        term = q_next ? TERM_Q : TERM_I;
        if (term == TERM_I) begin
            lo_op[0] = pr_s1;  x_op[0] = pr_x0;
            lo_op[1] = pr_s0;  x_op[1] = pr_x1;
        end else begin
            lo_op[0] = pr_c0;  x_op[0] = pr_x1;
            lo_op[1] = pr_c1;  x_op[1] = pr_x0;
        end
    end

    // One registered signed multiplier per lane.
    for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prod[ln] <= '0;
            end else if (pr_go || q_next) begin
                prod[ln] <= lo_op[ln] * x_op[ln];
            end
        end
    end

    // Sequence the I then Q step and carry the strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_next    <= 1'b0;
            prod_vld  <= 1'b0;
            prod_term <= TERM_I;
            prod_trig <= 1'b0;
        end else begin
            q_next    <= pr_go;
            prod_vld  <= pr_go | q_next;
            prod_term <= term;
            prod_trig <= pr_go & pr_trig;
        end
    end

    assign prod_a = prod[0];
    assign prod_b = prod[1];
endmodule

// File: rtl/iqdc_round_out.sv
// Output stage: subtracts the lane products at full precision, drops the LO
// fraction bits (floor), clamps to the output width and registers the word
// with its strobes. Assumes the LO magnitude stays below 2^(L_W-1).
module iqdc_round_out
    import iqdc_pkg::*;
#(
    parameter int unsigned X_W = 16,
    parameter int unsigned L_W = 18,
    parameter int unsigned O_W = 16,
    localparam int unsigned P_W  = X_W + L_W,
    localparam int unsigned D_W  = P_W + 1,
    localparam int unsigned FRAC = L_W - 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic signed [P_W-1:0] prod_a,
    input  logic signed [P_W-1:0] prod_b,
    input  logic                  prod_vld,
    input  term_e                 prod_term,
    input  logic                  prod_trig,
    output logic signed [O_W-1:0] out_data,
    output logic                  out_gate,
    output logic                  out_trig
);
    localparam logic signed [D_W-1:0] MAX_V = D_W'((64'sd1 <<< (O_W - 1)) - 1);
    localparam logic signed [D_W-1:0] MIN_V = -MAX_V - D_W'(1);

    logic signed [D_W-1:0] diff;
    logic signed [D_W-1:0] scaled;
    logic signed [O_W-1:0] clamped;

    // Full-precision difference, floor scaling and saturation.
    always_comb begin
        diff   = {prod_a[P_W-1], prod_a} - {prod_b[P_W-1], prod_b};
        scaled = diff >>> FRAC;
        if (scaled > MAX_V) begin
            clamped = MAX_V[O_W-1:0];
        end else if (scaled < MIN_V) begin
            clamped = MIN_V[O_W-1:0];
        end else begin
            clamped = scaled[O_W-1:0];
        end
    end

    // Output register: data updates only with a valid word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
            out_gate <= 1'b0;
            out_trig <= 1'b0;
        end else begin
            out_gate <= prod_vld;
            out_trig <= prod_trig && (prod_term == TERM_I);
            if (prod_vld) begin
                out_data <= clamped;
            end
        end
    end
endmodule

// File: rtl/iq_pair_downconv.sv
// Pairwise IQ downconverter top. Connects pair capture, the shared multiplier
// stage and the output stage. Fixed latency: I leaves two edges after the
// second sample is captured, Q one cycle later.
// Assumes ADC_W and LO_W fit the target's signed multipliers.
module iq_pair_downconv #(
    parameter int unsigned ADC_W = 16,
    parameter int unsigned LO_W  = 18,
    parameter int unsigned OUT_W = 16,
    localparam int unsigned PROD_W = ADC_W + LO_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pair_sel,
    input  logic signed [LO_W-1:0]  lo_cos,
    input  logic signed [LO_W-1:0]  lo_sin,
    input  logic signed [ADC_W-1:0] adc_data,
    input  logic                    adc_gate,
    input  logic                    adc_trig,
    output logic signed [OUT_W-1:0] iq_data,
    output logic                    iq_gate,
    output logic                    iq_trig,
    output logic                    phase_err
);
    import iqdc_pkg::*;

    logic signed [ADC_W-1:0]  pr_x0;
    logic signed [ADC_W-1:0]  pr_x1;
    logic signed [LO_W-1:0]   pr_c0;
    logic signed [LO_W-1:0]   pr_c1;
    logic signed [LO_W-1:0]   pr_s0;
    logic signed [LO_W-1:0]   pr_s1;
    logic                     pr_trig;
    logic                     pr_go;
    logic signed [PROD_W-1:0] prod_a;
    logic signed [PROD_W-1:0] prod_b;
    logic                     prod_vld;
    term_e                    prod_term;
    logic                     prod_trig;

    iqdc_pair_capture #(.X_W(ADC_W), .L_W(LO_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_gate (adc_gate),
        .smp_sel  (pair_sel),
        .smp_trig (adc_trig),
        .smp_x    (adc_data),
        .smp_c    (lo_cos),
        .smp_s    (lo_sin),
        .pr_x0    (pr_x0),
        .pr_x1    (pr_x1),
        .pr_c0    (pr_c0),
        .pr_c1    (pr_c1),
        .pr_s0    (pr_s0),
        .pr_s1    (pr_s1),
        .pr_trig  (pr_trig),
        .pr_go    (pr_go),
        .ph_err   (phase_err)
    );

    iqdc_mult_stage #(.X_W(ADC_W), .L_W(LO_W)) u_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .pr_x0     (pr_x0),
        .pr_x1     (pr_x1),
        .pr_c0     (pr_c0),
        .pr_c1     (pr_c1),
        .pr_s0     (pr_s0),
        .pr_s1     (pr_s1),
        .pr_trig   (pr_trig),
        .pr_go     (pr_go),
        .prod_a    (prod_a),
        .prod_b    (prod_b),
        .prod_vld  (prod_vld),
        .prod_term (prod_term),
        .prod_trig (prod_trig)
    );

    iqdc_round_out #(.X_W(ADC_W), .L_W(LO_W), .O_W(OUT_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .prod_a    (prod_a),
        .prod_b    (prod_b),
        .prod_vld  (prod_vld),
        .prod_term (prod_term),
        .prod_trig (prod_trig),
        .out_data  (iq_data),
        .out_gate  (iq_gate),
        .out_trig  (iq_trig)
    );
endmodule

// File: rtl/iqdc_checker.sv
// Checker for the pairwise IQ downconverter, bound to the top. It keeps its
// own model of the expected pair select and checks the strobe structure.
module iqdc_checker #(
    parameter int unsigned OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pair_sel,
    input logic             adc_gate,
    input logic [OUT_W-1:0] iq_data,
    input logic             iq_gate,
    input logic             iq_trig,
    input logic             phase_err
);
    logic ref_sel;

    // Independent tracking of which pair select is due next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_sel <= 1'b0;
        end else if (adc_gate) begin
            ref_sel <= ~pair_sel;
        end
    end

    // R4
    out_pair_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iq_gate) |=> iq_gate);

    // R4
    out_after_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iq_gate) |-> ($past(adc_gate, 3) && $past(pair_sel, 3)));

    // R5
    trig_in_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iq_trig |-> iq_gate);

    // R5
    trig_then_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iq_trig |=> (iq_gate && !iq_trig));

    // R7
    mism_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_gate && (pair_sel != ref_sel)) |=> phase_err);

    // R7
    match_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_gate && (pair_sel == ref_sel)) |=> !phase_err);

    // R6
    idle_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_gate |=> !phase_err);

    // R10
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !iq_gate |-> $stable(iq_data));
endmodule

bind iq_pair_downconv iqdc_checker #(.OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pair_sel  (pair_sel),
    .adc_gate  (adc_gate),
    .iq_data   (iq_data),
    .iq_gate   (iq_gate),
    .iq_trig   (iq_trig),
    .phase_err (phase_err)
);

// File: tb/iq_pair_downconv_tb.sv
// Bench for the pairwise IQ downconverter: sinusoidal and random stimulus
// with a fixed seed plus directed corners, checked against a reference model.
module iq_pair_downconv_tb;
    localparam int CLK_P = 10;
    localparam int DEPTH = 8192;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               pair_sel = 1'b0;
    logic signed [17:0] lo_cos = '0;
    logic signed [17:0] lo_sin = '0;
    logic signed [15:0] adc_data = '0;
    logic               adc_gate = 1'b0;
    logic               adc_trig = 1'b0;
    logic signed [15:0] iq_data;
    logic               iq_gate;
    logic               iq_trig;
    logic               phase_err;

    int checks = 0;
    int errors = 0;
    int nedges = 0;
    bit chk_on = 1'b0;

    bit               e_gate [DEPTH];
    bit               e_trig [DEPTH];
    bit               e_err  [DEPTH];
    bit               e_q    [DEPTH];
    bit               e_sat  [DEPTH];
    logic signed [15:0] e_data [DEPTH];
    logic signed [15:0] last_data = '0;

    bit                 m_sel = 1'b0;
    logic signed [15:0] m_x0 = '0;
    logic signed [17:0] m_c0 = '0;
    logic signed [17:0] m_s0 = '0;
    bit                 m_t0 = 1'b0;
    int                 n_smp = 0;

    iq_pair_downconv u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pair_sel  (pair_sel),
        .lo_cos    (lo_cos),
        .lo_sin    (lo_sin),
        .adc_data  (adc_data),
        .adc_gate  (adc_gate),
        .adc_trig  (adc_trig),
        .iq_data   (iq_data),
        .iq_gate   (iq_gate),
        .iq_trig   (iq_trig),
        .phase_err (phase_err)
    );

    always #(CLK_P / 2) clk = ~clk;

    always @(posedge clk) nedges <= nedges + 1;

    function automatic logic signed [15:0] sat16(input longint v, output bit s);
        s = 1'b0;
        if (v > 32767) begin
            s = 1'b1;
            return 16'sd32767;
        end
        if (v < -32768) begin
            s = 1'b1;
            return -16'sd32768;
        end
        return 16'(v);
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at edge %0d: actual %0d expected %0d", tag, nedges, act, exp);
        end
    endtask

    // Drive one cycle of input and update the reference model.
    task automatic drive(input bit g, input bit sel, input logic signed [15:0] x,
                         input logic signed [17:0] c, input logic signed [17:0] s, input bit t);
        int      k;
        bit      mism;
        longint  vi;
        longint  vq;
        bit      si;
        bit      sq;
        @(negedge clk);
        adc_gate = g;
        pair_sel = sel;
        adc_data = x;
        lo_cos   = c;
        lo_sin   = s;
        adc_trig = t;
        k = nedges + 1;
        if (g && k + 3 < DEPTH) begin
            mism = (sel != m_sel);
            if (mism) e_err[k] = 1'b1;
            m_sel = !sel;
            if (!sel) begin
                m_x0 = x; m_c0 = c; m_s0 = s; m_t0 = t;
            end else if (!mism) begin
                vi = (longint'(s) * longint'(m_x0) - longint'(m_s0) * longint'(x)) >>> 17;
                vq = (longint'(m_c0) * longint'(x) - longint'(c) * longint'(m_x0)) >>> 17;
                e_gate[k+2] = 1'b1; e_q[k+2] = 1'b0; e_trig[k+2] = m_t0 | t;
                e_data[k+2] = sat16(vi, si); e_sat[k+2] = si;
                e_gate[k+3] = 1'b1; e_q[k+3] = 1'b1; e_trig[k+3] = 1'b0;
                e_data[k+3] = sat16(vq, sq); e_sat[k+3] = sq;
            end
        end
    endtask

    // Sinusoidal sample with the LO words of the same instant.
    task automatic sine_sample(input bit g, input bit sel, input real w, input real wa, input bit t);
        real a;
        int  x;
        a = w * real'(n_smp);
        x = int'(20000.0 * $cos(wa * real'(n_smp) + 0.4)) + int'($urandom_range(200)) - 100;
        drive(g, sel, 16'(x), 18'(int'(131071.0 * $cos(a))), 18'(int'(131071.0 * $sin(a))), t);
        if (g) n_smp++;
    endtask

    // Observe outputs away from the clock edge.
    always @(negedge clk) begin
        if (chk_on && nedges < DEPTH) begin
            // R4 R6 R8: a valid word only where the model placed one
            check(iq_gate == e_gate[nedges], "R4 R6 R8 iq_gate", longint'(iq_gate), longint'(e_gate[nedges]));
            // R5: trigger on the I word only
            check(iq_trig == e_trig[nedges], "R5 iq_trig", longint'(iq_trig), longint'(e_trig[nedges]));
            // R7: one-cycle mismatch flag
            check(phase_err == e_err[nedges], "R7 phase_err", longint'(phase_err), longint'(e_err[nedges]));
            if (e_gate[nedges]) begin
                check(iq_data == e_data[nedges],
                      e_sat[nedges] ? "R3 saturated word" : (e_q[nedges] ? "R2 Q word" : "R1 I word"),
                      longint'(iq_data), longint'(e_data[nedges]));
                last_data = e_data[nedges];
            end else begin
                // R10: hold while not gated
                check(iq_data == last_data, "R10 data hold", longint'(iq_data), longint'(last_data));
            end
        end
    end

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20517));
        for (int i = 0; i < DEPTH; i++) begin
            e_gate[i] = 1'b0; e_trig[i] = 1'b0; e_err[i] = 1'b0;
            e_q[i] = 1'b0; e_sat[i] = 1'b0; e_data[i] = '0;
        end
        // Garbage on inputs during reset
        adc_gate = 1'b1; pair_sel = 1'b1; adc_data = 16'sd1234; adc_trig = 1'b1;
        repeat (4) @(negedge clk);
        // R9: reset values
        check(iq_gate == 1'b0 && iq_trig == 1'b0 && phase_err == 1'b0, "R9 strobes in reset",
              longint'({iq_gate, iq_trig, phase_err}), 0);
        check(iq_data == 16'sd0, "R9 data in reset", longint'(iq_data), 0);
        adc_gate = 1'b0; pair_sel = 1'b0; adc_trig = 1'b0;
        rst_n = 1'b1;
        chk_on = 1'b1;

        // Back-to-back pairs with a sinusoidal LO (R1 R2 R4)
        for (int i = 0; i < 240; i++) sine_sample(1'b1, 1'(i % 2), 0.81, 0.77, (i % 37) == 3);

        // Random idle gaps and triggers; idle cycles carry garbage (R6)
        for (int i = 0; i < 500; i++) begin
            if ($urandom_range(99) < 30) begin
                drive(1'b0, 1'($urandom), 16'($urandom), 18'($urandom_range(200000)),
                      18'($urandom_range(200000)), 1'($urandom));
            end else begin
                sine_sample(1'b1, m_sel, 2.1, 1.3, $urandom_range(9) == 0);
            end
        end

        // Random data with random LO words, back to back
        for (int i = 0; i < 300; i++) begin
            drive(1'b1, m_sel, 16'($urandom), 18'(int'($urandom_range(262142)) - 131071),
                  18'(int'($urandom_range(262142)) - 131071), 1'($urandom_range(7) == 0));
        end

        // R3: both rails
        drive(1'b1, 1'b0, 16'sd32767, 18'sd131071, -18'sd131071, 1'b0);
        drive(1'b1, 1'b1, 16'sd32767, -18'sd131071, 18'sd131071, 1'b1);
        drive(1'b1, 1'b0, -16'sd32768, 18'sd131071, -18'sd131071, 1'b0);
        drive(1'b1, 1'b1, 16'sd32767, -18'sd131071, 18'sd131071, 1'b0);
        drive(1'b1, 1'b0, 16'sd32767, -18'sd131071, 18'sd131071, 1'b0);
        drive(1'b1, 1'b1, -16'sd32768, 18'sd131071, -18'sd131071, 1'b0);

        // R7 R8: a second sample when a first is due is dropped
        drive(1'b0, 1'b0, '0, '0, '0, 1'b0);
        drive(1'b1, 1'b1, 16'sd5000, 18'sd90000, 18'sd70000, 1'b1);
        drive(1'b1, 1'b0, 16'sd3000, 18'sd60000, -18'sd50000, 1'b0);
        drive(1'b1, 1'b1, -16'sd7000, 18'sd40000, 18'sd80000, 1'b0);
        // R7 R8: two first samples in a row; the later one starts the pair
        drive(1'b1, 1'b0, 16'sd100, 18'sd10000, 18'sd20000, 1'b1);
        drive(1'b1, 1'b0, 16'sd12000, -18'sd100000, 18'sd30000, 1'b0);
        drive(1'b1, 1'b1, 16'sd9000, 18'sd50000, -18'sd110000, 1'b0);

        // Idle tail with garbage, data must hold (R6 R10)
        for (int i = 0; i < 12; i++) drive(1'b0, 1'($urandom), 16'($urandom), '0, '0, 1'($urandom));
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule